// File: doc/BRIEF.md
# Dynamic-Focus Delay-and-Sum Receive Beamformer

This block forms one beam sample per clock from a phased array whose receive channels each deliver one signed sample per clock. Each channel is delayed by an integer number of samples plus a fraction of a sample, and the fraction is realised by linear interpolation between the two samples on either side of it. The delayed value is scaled by a per-channel apodization weight, and all channels are added in a registered adder tree. The sum is then rounded and saturated to the sample width.

Focus follows depth. Along a scan line, the output samples are grouped into depth zones of `ZONE_LEN` samples each. Every zone has its own set of delays and weights, held in an on-chip coefficient memory that the host fills through a simple write port. While one zone is being processed, the next set is fetched into a shadow bank. That bank becomes active on the first sample of the new zone. A `line_start` pulse restarts the depth sequence, and the block then emits `LINE_LEN` samples flagged valid, the last of them also flagged last.

Usage conditions:
- `ZONE_LEN` must be at least `NCH+2`.
- `NCH` must be at least 2.
- `line_start` may only be pulsed when no line is running.
- At least `NCH+3` idle cycles must pass between the last coefficient write, or the final input sample of the previous line, and the next `line_start`.

Top module: `bf_dyn_focus`

## Requirements
- R1: When `rst` is sampled high, `out_valid` and `out_last` are low and `out_beam` is zero from the next cycle on. A line in progress is abandoned and yields no further valid outputs.
- R2: For a `line_start` pulse in cycle T, `out_valid` is high in exactly the cycles T+L through T+L+LINE_LEN-1, where L = 3 + ceil(log2(NCH)). It is low in all other cycles.
- R3: `out_last` is high only in the cycle carrying sample n = LINE_LEN-1, and it is never high without `out_valid`.
- R4: Sample n of channel c is formed from a = x_c[n-d] and b = x_c[n-d-1], where x_c[n] is the channel input in the cycle T+n, d is the unsigned integer delay and f is the unsigned fractional delay in units of 2^-DFW samples. The interpolated value is a*(2^DFW - f) + b*f.
- R5: The beam sample is S = sum over channels of interp_c * w_c, with w_c an unsigned Q1.15 weight. The output is floor((S + 2^(SH-1)) / 2^SH) with SH = WW-1+DFW. A channel whose weight is 0 has no effect on the output.
- R6: A rounded result above 2^(SW-1)-1 is output as 2^(SW-1)-1, and one below -2^(SW-1) is output as -2^(SW-1).
- R7: Sample n uses the coefficient set of zone z = min(floor(n/ZONE_LEN), NZONES-1). Channel c of zone z is stored at address z*NCH + c. The word holds the weight in bits [WW-1:0], the fraction in bits [WW+DFW-1:WW] and the integer delay in the bits above.
- R8: Every output sample is computed from a single zone's set. The active coefficient bank changes only on a swap, which happens at line start or on a zone boundary.
- R9: The depth sequence restarts at every `line_start`, so sample 0 of every line uses zone 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | One-cycle pulse marking sample 0 of a scan line |
| s_data | input | NCH*SW | Channel samples, channel c in bits [c*SW +: SW], two's complement |
| cw_en | input | 1 | Coefficient memory write enable |
| cw_addr | input | clog2(NZONES*NCH) | Coefficient word address, zone*NCH + channel |
| cw_data | input | DIW+DFW+WW | Coefficient word {integer delay, fraction, weight} |
| out_beam | output | SW | Rounded, saturated beam sample |
| out_valid | output | 1 | Beam sample is valid |
| out_last | output | 1 | Final sample of the line |

## Verification
The bench drives lines long enough to run past the last zone, so the clamped final set is exercised. A counter that failed to clamp, or a swap placed one cycle early or late, would produce wrong beam values around each boundary. Other lines use the largest integer delay, an exact half-sample fraction and a zero-weight channel fed with full-scale noise. These catch a tap that is off by one, interpolation weights applied to the wrong neighbour, and a channel that leaks into the sum. Constant full-scale inputs at maximum weight drive the sum past both rails, so a missing or wrapping clamp shows up as a sign flip. A reset in the middle of a line checks that the flag pipeline is cleared rather than left to drain stale valid samples.

// File: rtl/bf_pkg.sv
package bf_pkg;
  // default widths shared by the beamformer modules
  localparam int BF_SAMPLE_W = 16;
  localparam int BF_WEIGHT_W = 16;
  localparam int BF_DINT_W   = 6;
  localparam int BF_DFRAC_W  = 4;
endpackage

// File: rtl/bf_chan.sv
// One channel: delay line, fractional interpolation, apodization product.
module bf_chan #(
  parameter int SW  = 16,
  parameter int DIW = 6,
  parameter int DFW = 4,
  parameter int WW  = 16,
  parameter int IW  = SW + DFW + 1,
  parameter int PW  = IW + WW + 1
) (
  input  logic                 clk,
  input  logic [SW-1:0]        x,
  input  logic [DIW-1:0]       dly,
  input  logic [DFW-1:0]       frac,
  input  logic [WW-1:0]        wgt,
  output logic signed [PW-1:0] prod
);
  localparam int DEPTH = 1 << DIW;   // holds x[n-1] .. x[n-2^DIW]
  localparam int ONE   = 1 << DFW;

  logic [SW-1:0]        hist [0:DEPTH-1];
  logic [SW-1:0]        tap_a, tap_b;
  logic [DFW:0]         fa;
  logic signed [IW-1:0] a_e, b_e, mix, mix_q;
  logic [WW-1:0]        w_q;

  always_ff @(posedge clk) begin
    hist[0] <= x;
    for (int i = 1; i < DEPTH; i++) hist[i] <= hist[i-1];
  end

  always_comb begin
    tap_a = (dly == '0) ? x : hist[dly - 1'b1];
    tap_b = hist[dly];
    fa    = (DFW+1)'(ONE) - {1'b0, frac};
    a_e   = IW'($signed(tap_a));
    b_e   = IW'($signed(tap_b));
    mix   = a_e * $signed({{(IW-DFW-1){1'b0}}, fa})
          + b_e * $signed({{(IW-DFW){1'b0}}, frac});
  end

  always_ff @(posedge clk) begin
    mix_q <= mix;
    w_q   <= wgt;
    prod  <= PW'(mix_q) * $signed({{(PW-WW){1'b0}}, w_q});
  end
endmodule

// File: rtl/bf_sum_tree.sv
// Registered binary adder tree with round-half-up and saturation.
module bf_sum_tree #(
  parameter int NCH = 30,
  parameter int PW  = 38,
  parameter int SW  = 16,
  parameter int SH  = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH*PW-1:0] prod_flat,
  output logic [SW-1:0]     beam
);
  localparam int LVL    = $clog2(NCH);
  localparam int LEAVES = 1 << LVL;
  localparam int AW     = PW + LVL;
  localparam logic signed [AW-1:0] PMAX = AW'((1 << (SW-1)) - 1);
  localparam logic signed [AW-1:0] NMIN = ~PMAX;
  localparam logic signed [AW-1:0] HALF = AW'(1) <<< (SH-1);

  logic signed [AW-1:0] lf [0:LEAVES-1];
  logic signed [AW-1:0] nd [1:LEAVES-1];
  logic signed [AW-1:0] rnd, shf;

  always_comb begin
    for (int c = 0; c < LEAVES; c++)
      lf[c] = (c < NCH) ? AW'($signed(prod_flat[c*PW +: PW])) : '0;
  end

  for (genvar i = 1; i < LEAVES; i++) begin : g_node
    if (2*i >= LEAVES) begin : g_leaf
      always_ff @(posedge clk) nd[i] <= lf[2*i-LEAVES] + lf[2*i+1-LEAVES];
    end else begin : g_inner
      always_ff @(posedge clk) nd[i] <= nd[2*i] + nd[2*i+1];
    end
  end

  always_comb begin
    rnd = nd[1] + HALF;
    shf = rnd >>> SH;
  end

  always_ff @(posedge clk) begin
    if (rst)              beam <= '0;
    else if (shf > PMAX)  beam <= PMAX[SW-1:0];
    else if (shf < NMIN)  beam <= NMIN[SW-1:0];
    else                  beam <= shf[SW-1:0];
  end
endmodule

// File: rtl/bf_coef_seq.sv
// Coefficient memory, depth-zone sequencing and shadow/active banks.
module bf_coef_seq #(
  parameter int NCH      = 30,
  parameter int CW       = 26,
  parameter int ZONE_LEN = 40,
  parameter int NZONES   = 16,
  parameter int LINE_LEN = 1024
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             line_start,
  input  logic                             cw_en,
  input  logic [$clog2(NZONES*NCH)-1:0]    cw_addr,
  input  logic [CW-1:0]                    cw_data,
  output logic [NCH*CW-1:0]                cur,
  output logic [NCH*CW-1:0]                act_flat,
  output logic                             swap,
  output logic                             in_line,
  output logic                             in_last
);
  localparam int DEPTH = NZONES * NCH;
  localparam int CAW   = $clog2(DEPTH);
  localparam int PCW   = $clog2(LINE_LEN + 1);
  localparam int ZCW   = $clog2(ZONE_LEN + 1);
  localparam int ZNW   = (NZONES > 1) ? $clog2(NZONES) : 1;
  localparam int FCW   = $clog2(NCH + 1);

  logic [CW-1:0]  mem [0:DEPTH-1];
  logic [CW-1:0]  mem_q;
  logic [CW-1:0]  shadow [0:NCH-1];
  logic [CW-1:0]  active [0:NCH-1];
  logic           running, swap_q, line_end, fetch_go, rd_v;
  logic [PCW-1:0] pos;
  logic [ZCW-1:0] ph;
  logic [ZNW-1:0] zone, tgt;
  logic [FCW-1:0] fc, rd_ch;
  logic [CAW-1:0] raddr;

  always_comb begin
    swap     = line_start | swap_q;
    line_end = running && (pos == PCW'(LINE_LEN - 1));
    in_line  = line_start | running;
    in_last  = line_start ? (LINE_LEN == 1) : line_end;
    tgt      = !running ? '0 : (zone == ZNW'(NZONES - 1)) ? zone : zone + 1'b1;
    fetch_go = !swap && (!running || fc < FCW'(NCH));
    raddr    = CAW'(tgt) * CAW'(NCH) + CAW'(fc);
  end

  for (genvar c = 0; c < NCH; c++) begin : g_out
    assign cur[c*CW +: CW]      = swap ? shadow[c] : active[c];
    assign act_flat[c*CW +: CW] = active[c];
  end

  // simple dual-port memory, synchronous read
  always_ff @(posedge clk) begin
    if (cw_en) mem[cw_addr] <= cw_data;
    mem_q <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0; pos <= '0; ph <= '0; zone <= '0;
      swap_q  <= 1'b0; fc  <= '0; rd_v <= 1'b0; rd_ch <= '0;
    end else begin
      swap_q <= running && !line_start && !line_end
             && ph == ZCW'(ZONE_LEN - 1) && zone != ZNW'(NZONES - 1);
      if (line_start) begin
        running <= (LINE_LEN > 1);
        pos     <= PCW'(1);
        ph      <= ZCW'(1);
        zone    <= '0;
      end else if (running) begin
        pos <= pos + 1'b1;
        if (line_end) running <= 1'b0;
        if (ph == ZCW'(ZONE_LEN - 1)) begin
          ph <= '0;
          if (zone != ZNW'(NZONES - 1)) zone <= zone + 1'b1;
        end else begin
          ph <= ph + 1'b1;
        end
      end
      if (swap || line_end) fc <= '0;
      else if (fetch_go)
        fc <= (fc == FCW'(NCH - 1)) ? (running ? FCW'(NCH) : '0) : fc + 1'b1;
      rd_v  <= fetch_go;
      rd_ch <= fc;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin
        shadow[c] <= '0;
        active[c] <= '0;
      end
    end else begin
      if (rd_v) shadow[rd_ch] <= mem_q;
      if (swap)
        for (int c = 0; c < NCH; c++) active[c] <= shadow[c];
    end
  end
endmodule

// File: rtl/bf_dyn_focus.sv
// Top: dynamic-focus delay-and-sum receive beamformer.
module bf_dyn_focus import bf_pkg::*; #(
  parameter int NCH      = 30,
  parameter int SW       = BF_SAMPLE_W,
  parameter int WW       = BF_WEIGHT_W,
  parameter int DIW      = BF_DINT_W,
  parameter int DFW      = BF_DFRAC_W,
  parameter int ZONE_LEN = 40,
  parameter int NZONES   = 16,
  parameter int LINE_LEN = 1024
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   line_start,
  input  logic [NCH*SW-1:0]                      s_data,
  input  logic                                   cw_en,
  input  logic [$clog2(NZONES*NCH)-1:0]          cw_addr,
  input  logic [DIW+DFW+WW-1:0]                  cw_data,
  output logic [SW-1:0]                          out_beam,
  output logic                                   out_valid,
  output logic                                   out_last
);
  localparam int CW  = DIW + DFW + WW;
  localparam int IW  = SW + DFW + 1;
  localparam int PW  = IW + WW + 1;
  localparam int LAT = 3 + $clog2(NCH);
  localparam int SH  = WW - 1 + DFW;

  logic [NCH*CW-1:0] cur, act_flat;
  logic [NCH*PW-1:0] prod_flat;
  logic              swap, in_line, in_last;
  logic [LAT-1:0]    vp, lp;

  bf_coef_seq #(.NCH(NCH), .CW(CW), .ZONE_LEN(ZONE_LEN), .NZONES(NZONES),
                .LINE_LEN(LINE_LEN)) u_seq (
    .clk(clk), .rst(rst), .line_start(line_start),
    .cw_en(cw_en), .cw_addr(cw_addr), .cw_data(cw_data),
    .cur(cur), .act_flat(act_flat), .swap(swap),
    .in_line(in_line), .in_last(in_last));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [CW-1:0] cf;
    assign cf = cur[c*CW +: CW];
    bf_chan #(.SW(SW), .DIW(DIW), .DFW(DFW), .WW(WW), .IW(IW), .PW(PW)) u_ch (
      .clk(clk), .x(s_data[c*SW +: SW]),
      .dly(cf[CW-1 -: DIW]), .frac(cf[WW +: DFW]), .wgt(cf[WW-1:0]),
      .prod(prod_flat[c*PW +: PW]));
  end

  bf_sum_tree #(.NCH(NCH), .PW(PW), .SW(SW), .SH(SH)) u_tree (
    .clk(clk), .rst(rst), .prod_flat(prod_flat), .beam(out_beam));

  always_ff @(posedge clk) begin
    if (rst) begin
      vp <= '0;
      lp <= '0;
    end else begin
      vp <= {vp[LAT-2:0], in_line};
      lp <= {lp[LAT-2:0], in_last};
    end
  end

  assign out_valid = vp[LAT-1];
  assign out_last  = lp[LAT-1];
endmodule

// File: rtl/bf_dyn_focus_chk.sv
// Protocol checker bound to the beamformer top.
module bf_dyn_focus_chk #(
  parameter int NCH = 30,
  parameter int CW  = 26,
  parameter int LAT = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              line_start,
  input logic              out_valid,
  input logic              out_last,
  input logic              swap,
  input logic [NCH*CW-1:0] act
);
  logic [7:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                           cnt <= '0;
    else if (line_start)               cnt <= 8'd1;
    else if (cnt != 0 && cnt <= LAT)   cnt <= cnt + 8'd1;
  end

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !out_last));

  a_r2_first_valid: assert property (@(posedge clk) disable iff (rst)
    (cnt == 8'(LAT)) |-> out_valid);

  a_r2_rise_time: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> (cnt == 8'(LAT)));

  a_r3_last_valid: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  a_r3_valid_run: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_last) |=> out_valid);

  a_r8_bank_hold: assert property (@(posedge clk) disable iff (rst)
    !swap |=> $stable(act));
endmodule

bind bf_dyn_focus bf_dyn_focus_chk #(.NCH(NCH), .CW(CW), .LAT(LAT)) u_chk (
  .clk(clk), .rst(rst), .line_start(line_start), .out_valid(out_valid),
  .out_last(out_last), .swap(swap), .act(act_flat));

// File: tb/tb_bf_dyn_focus.sv
`timescale 1ns/1ps
module tb_bf_dyn_focus;
  localparam int NCH = 4, SW = 16, WW = 16, DIW = 4, DFW = 4;
  localparam int ZL = 8, NZ = 4, LL = 40;
  localparam int LAT = 5;
  localparam int CW = DIW + DFW + WW;
  localparam int CAW = $clog2(NZ*NCH);
  localparam int MAXK = 2048;

  // entry: {coef kind[31:24], sample mode[23:16], seed[15:0]}
  localparam logic [31:0] TBL [6] = '{
    {8'd0, 8'd0, 16'd11}, {8'd0, 8'd1, 16'd22}, {8'd2, 8'd0, 16'd33},
    {8'd3, 8'd0, 16'd44}, {8'd1, 8'd2, 16'd55}, {8'd1, 8'd3, 16'd66}};

  logic clk = 0, rst = 1, line_start = 0, cw_en = 0;
  logic [NCH*SW-1:0] s_data = '0;
  logic [CAW-1:0] cw_addr = '0;
  logic [CW-1:0]  cw_data = '0;
  logic [SW-1:0]  out_beam;
  logic out_valid, out_last;

  always #2 clk = ~clk;

  bf_dyn_focus #(.NCH(NCH), .SW(SW), .WW(WW), .DIW(DIW), .DFW(DFW),
                 .ZONE_LEN(ZL), .NZONES(NZ), .LINE_LEN(LL)) dut (
    .clk(clk), .rst(rst), .line_start(line_start), .s_data(s_data),
    .cw_en(cw_en), .cw_addr(cw_addr), .cw_data(cw_data),
    .out_beam(out_beam), .out_valid(out_valid), .out_last(out_last));

  int checks = 0, fails = 0, k = 0, t0 = -100000, mode = 0;
  bit chk_en = 0, done = 0;
  logic [31:0] st = 32'h1234_5678;
  int hx [NCH][MAXK];
  logic [CW-1:0] cm [NZ][NCH];
  string btag = "R4 R5 R7 R8 R9";

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, k);
    end
  endtask

  function automatic logic [CW-1:0] coef_gen(int kind, int seed, int z, int ch);
    logic [31:0] h;
    h = 32'(seed) * 32'h9E3779B1 ^ 32'(z) * 32'h85EBCA6B ^ 32'(ch) * 32'hC2B2AE35;
    h = h ^ (h >> 16);
    h = h * 32'h27D4EB2F;
    h = h ^ (h >> 15);
    case (kind)
      1: return {4'(ch + z*4), 4'd0, 16'hFFFF};
      2: return (ch == 1) ? {h[3:0], h[7:4], 16'h0000} : {h[3:0], h[7:4], h[31:16]};
      3: return {4'((z*5 + ch*3) % 16), 4'd8, 16'h8000};
      default: return {h[3:0], h[7:4], h[31:16]};
    endcase
  endfunction

  function automatic logic [SW-1:0] next_sample();
    st = st ^ (st << 13);
    st = st ^ (st >> 17);
    st = st ^ (st << 5);
    case (mode)
      1: return SW'($signed(st[15:0]) >>> 6);
      2: return 16'h7FFF;
      3: return 16'h8000;
      default: return st[15:0];
    endcase
  endfunction

  function automatic longint model(int n);
    longint sum, a, b, d, f, w, r;
    int z;
    z = n / ZL;
    if (z > NZ - 1) z = NZ - 1;
    sum = 0;
    for (int ch = 0; ch < NCH; ch++) begin
      d = longint'(cm[z][ch][CW-1 -: DIW]);
      f = longint'(cm[z][ch][WW +: DFW]);
      w = longint'(cm[z][ch][WW-1:0]);
      a = hx[ch][t0 + n - int'(d)];
      b = hx[ch][t0 + n - int'(d) - 1];
      sum += (a * (16 - f) + b * f) * w;
    end
    r = (sum + (longint'(1) <<< 18)) >>> 19;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  task automatic tick(bit ls, bit we, int addr, logic [CW-1:0] wd);
    int n;
    @(negedge clk);
    k++;
    if (chk_en) begin
      n = k - t0 - LAT;
      if (n >= 0 && n < LL) begin
        chk(out_valid === 1'b1, "R2 valid window", out_valid, 1);
        chk(out_last === (n == LL-1), "R3 last flag", out_last, (n == LL-1));
        chk($signed(out_beam) == model(n), btag, $signed(out_beam), model(n));
      end else begin
        chk(out_valid === 1'b0, "R2 idle valid", out_valid, 0);
        chk(out_last === 1'b0, "R3 idle last", out_last, 0);
      end
    end
    line_start = ls;
    if (ls) t0 = k;
    cw_en = we;
    cw_addr = CAW'(addr);
    cw_data = wd;
    for (int ch = 0; ch < NCH; ch++) begin
      logic [SW-1:0] v;
      v = next_sample();
      s_data[ch*SW +: SW] = v;
      hx[ch][k] = int'($signed(v));
    end
  endtask

  task automatic run_line(logic [31:0] e);
    int kind, seed;
    kind = int'(e[31:24]);
    mode = int'(e[23:16]);
    seed = int'(e[15:0]);
    case (kind)
      2: btag = "R5 zero-weight channel ignored";
      3: btag = "R4 half-sample interpolation";
      1: btag = "R6 saturation";
      default: btag = "R4 R5 R7 R8 R9 zone sequence";
    endcase
    for (int z = 0; z < NZ; z++)
      for (int ch = 0; ch < NCH; ch++) begin
        cm[z][ch] = coef_gen(kind, seed, z, ch);
        tick(0, 1, z*NCH + ch, cm[z][ch]);
      end
    repeat (2*NCH + 10) tick(0, 0, 0, '0);
    tick(1, 0, 0, '0);
    repeat (LL + LAT + 4) tick(0, 0, 0, '0);
  endtask

  initial begin
    repeat (4) tick(0, 0, 0, '0);
    chk(out_valid === 1'b0, "R1 reset valid", out_valid, 0);
    chk(out_last === 1'b0, "R1 reset last", out_last, 0);
    chk(out_beam === '0, "R1 reset beam", out_beam, 0);
    rst = 0;
    repeat (20) tick(0, 0, 0, '0);
    chk_en = 1;
    foreach (TBL[i]) run_line(TBL[i]);
    // R9: a second line with the same set restarts at zone 0
    tick(1, 0, 0, '0);
    repeat (LL + LAT + 4) tick(0, 0, 0, '0);
    // R1: reset in the middle of a line drops the rest of it
    mode = 0;
    btag = "R1 mid-line reset";
    repeat (2*NCH + 10) tick(0, 0, 0, '0);
    tick(1, 0, 0, '0);
    repeat (LAT + 6) tick(0, 0, 0, '0);
    rst = 1;
    t0 = -100000;
    repeat (2) tick(0, 0, 0, '0);
    rst = 0;
    repeat (LL + LAT + 10) tick(0, 0, 0, '0);
    chk(out_valid === 1'b0, "R1 no valid after reset", out_valid, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule